// File: doc/BRIEF.md
# Descriptor Ring Ownership Tracker

This block keeps the bookkeeping for two descriptor rings, one for transmit and one for receive. Software and a frame engine share these rings. Each descriptor is three words in memory: a buffer address, a byte size and a status word. The block does not hold a per-descriptor owner flag. It holds a producer position and a consumer position for each ring, and ownership follows from comparing them. Each position carries one lap bit beyond the slot index, so a ring with every slot handed over can be told apart from a ring with none.

Software programs each ring's base address and last slot index through a small word-addressed register port. It hands a transmit slot to the engine, or gives a receive slot back to it, by writing a one-shot done strobe. Software polls the status registers to learn whether the slot it points at is its own to use. The frame engine signals with single-cycle completion pulses. It reads the memory address of the next descriptor it should fetch from the block. Two level interrupts, "transmit space available" and "receive frame ready", follow the ring state through their own mask bits.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset both rings are empty at slot 0. Both last-index registers hold MAX_DESC-1. Both masks and both interrupts are 0. The transmit status register (0x4) reads 0 and the receive status register (0xC) reads 1.
- R2: Writing a word with bit 0 set to register 0x3 passes the transmit slot to the engine and advances the software transmit index. This index reads back at 0x3. After the slot equal to the last index it wraps to 0.
- R3: Register 0x4 reads 1 while every transmit slot is held by the engine and 0 otherwise. A transmit done strobe arriving while it reads 1 leaves the index unchanged.
- R4: A transmit completion pulse retires the oldest slot held by the engine, and is ignored when no slot is held. txFetchValid is high while a slot is held. txFetchAddr is the transmit base plus 12 times the engine's transmit slot.
- R5: A receive completion pulse fills the engine's receive slot and records rxEngErr for it. The pulse is ignored when every slot already waits for software. rxFetchValid is high while a slot is free. rxFetchAddr is the receive base plus 12 times the engine's receive slot.
- R6: Register 0xC bit 0 reads 0 when the software receive slot holds a completed frame and 1 otherwise. Bit 1 gives the recorded error flag of that frame, and reads 0 when no frame is pending.
- R7: Writing a word with bit 0 set to register 0xB releases the pending receive slot and advances the software receive index, which reads back at 0xB. The slot is released whether or not its frame was flagged bad. The strobe is ignored when no frame is pending.
- R8: txIrq equals mask bit 0 at 0x2 AND "transmit slot free" (0x4 reads 0). rxIrq equals mask bit 0 at 0xA AND "frame pending". Writing 0 to a mask silences its interrupt.
- R9: Writing a last-index register (0x1 transmit, 0x9 receive) sets that ring to last+1 slots. A value above MAX_DESC-1 is clamped to MAX_DESC-1. The write returns that ring to empty at slot 0 and clears its error flags.
- R10: The base registers (0x0, 0x8), the last-index registers and the mask registers (0x2, 0xA) read back what was written, zero-extended. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 4 | Word address for read and write |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| txEngDone | input | 1 | Engine finished one transmit descriptor |
| rxEngDone | input | 1 | Engine filled one receive descriptor |
| rxEngErr | input | 1 | Frame of the current rxEngDone pulse is bad |
| txFetchValid | output | 1 | A transmit descriptor awaits the engine |
| txFetchAddr | output | ADDR_W | Address of that transmit descriptor |
| rxFetchValid | output | 1 | A free receive descriptor is available to the engine |
| rxFetchAddr | output | ADDR_W | Address of that receive descriptor |
| txIrq | output | 1 | Transmit space available interrupt |
| rxIrq | output | 1 | Receive frame ready interrupt |

## Verification
The bench builds the block with MAX_DESC = 8. It then programs short rings: four and then three transmit slots, and two receive slots. This brings wrap-around, the full-ring lap-bit case and refused strobes within a few dozen register writes. The two-slot receive ring fills after two completions, so a bad frame and a good frame can be released in order. The bench also checks the same-cycle meeting of a software strobe and an engine pulse, as well as the clamp of an oversized last index against the build value of 8.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // Word addresses of the register port
  localparam logic [3:0] A_TX_BASE = 4'h0;
  localparam logic [3:0] A_TX_LAST = 4'h1;
  localparam logic [3:0] A_TX_MASK = 4'h2;
  localparam logic [3:0] A_TX_DONE = 4'h3; // write: hand over, read: software index
  localparam logic [3:0] A_TX_STAT = 4'h4;
  localparam logic [3:0] A_RX_BASE = 4'h8;
  localparam logic [3:0] A_RX_LAST = 4'h9;
  localparam logic [3:0] A_RX_MASK = 4'hA;
  localparam logic [3:0] A_RX_DONE = 4'hB; // write: release, read: software index
  localparam logic [3:0] A_RX_STAT = 4'hC;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic txHand;     // software gives a transmit slot to the engine
    logic txRetire;   // engine finished a transmit slot
    logic rxFill;     // engine filled a receive slot
    logic rxRelease;  // software returns a receive slot
    logic txRestart;  // transmit ring reprogrammed
    logic rxRestart;  // receive ring reprogrammed
  } ringStrobe_t;

  // Datapath-to-control ring state
  typedef struct packed {
    logic txFull;     // every transmit slot held by the engine
    logic txPending;  // at least one transmit slot held by the engine
    logic rxFull;     // every receive slot waits for software
    logic rxReady;    // at least one receive frame waits for software
    logic rxErrHead;  // error flag of the frame at the software receive slot
  } ringFlags_t;
endpackage

// File: rtl/ring_index.sv
// Slot position with a lap bit; wraps after the programmed last slot.
module ring_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [IDX_W-1:0] lastIdx,
  output logic [IDX_W-1:0] idx,
  output logic             lap
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx <= '0;
      lap <= 1'b0;
    end else if (advance) begin
      if (idx == lastIdx) begin
        idx <= '0;
        lap <= ~lap;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import ring_pkg::*;
#(
  parameter int MAX_DESC   = 16,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  ringStrobe_t       strobe,
  input  logic              rxEngErr,
  input  logic [ADDR_W-1:0] txBase,
  input  logic [ADDR_W-1:0] rxBase,
  input  logic [IDX_W-1:0]  txLast,
  input  logic [IDX_W-1:0]  rxLast,
  output ringFlags_t        flags,
  output logic [IDX_W-1:0]  txSwIdx,
  output logic [IDX_W-1:0]  rxSwIdx,
  output logic [IDX_W-1:0]  rxHwIdx,
  output logic              txFetchValid,
  output logic [ADDR_W-1:0] txFetchAddr,
  output logic              rxFetchValid,
  output logic [ADDR_W-1:0] rxFetchAddr
);
  logic [IDX_W-1:0] txHwIdx;
  logic txSwLap, txHwLap, rxSwLap, rxHwLap;
  logic [MAX_DESC-1:0] rxErrQ;

  // Transmit: software produces, engine consumes
  ring_index #(.IDX_W(IDX_W)) txProd_i (
    .clk(clk), .rst(rst), .clear(strobe.txRestart), .advance(strobe.txHand),
    .lastIdx(txLast), .idx(txSwIdx), .lap(txSwLap));
  ring_index #(.IDX_W(IDX_W)) txCons_i (
    .clk(clk), .rst(rst), .clear(strobe.txRestart), .advance(strobe.txRetire),
    .lastIdx(txLast), .idx(txHwIdx), .lap(txHwLap));

  // Receive: engine produces, software consumes
  ring_index #(.IDX_W(IDX_W)) rxProd_i (
    .clk(clk), .rst(rst), .clear(strobe.rxRestart), .advance(strobe.rxFill),
    .lastIdx(rxLast), .idx(rxHwIdx), .lap(rxHwLap));
  ring_index #(.IDX_W(IDX_W)) rxCons_i (
    .clk(clk), .rst(rst), .clear(strobe.rxRestart), .advance(strobe.rxRelease),
    .lastIdx(rxLast), .idx(rxSwIdx), .lap(rxSwLap));

  // Per-slot error flags written by the engine on each fill
  always_ff @(posedge clk) begin
    if (rst || strobe.rxRestart) begin
      rxErrQ <= '0;
    end else if (strobe.rxFill) begin
      rxErrQ[rxHwIdx] <= rxEngErr;
    end
  end

  always_comb begin
    flags.txFull    = (txSwIdx == txHwIdx) && (txSwLap != txHwLap);
    flags.txPending = (txSwIdx != txHwIdx) || (txSwLap != txHwLap);
    flags.rxFull    = (rxHwIdx == rxSwIdx) && (rxHwLap != rxSwLap);
    flags.rxReady   = (rxHwIdx != rxSwIdx) || (rxHwLap != rxSwLap);
    flags.rxErrHead = flags.rxReady && rxErrQ[rxSwIdx];
  end

  assign txFetchValid = flags.txPending;
  assign rxFetchValid = !flags.rxFull;
  assign txFetchAddr  = txBase + ADDR_W'(DESC_BYTES) * ADDR_W'(txHwIdx);
  assign rxFetchAddr  = rxBase + ADDR_W'(DESC_BYTES) * ADDR_W'(rxHwIdx);
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
#(
  parameter int MAX_DESC = 16,
  parameter int IDX_W    = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txEngDone,
  input  logic              rxEngDone,
  input  ringFlags_t        flags,
  input  logic [IDX_W-1:0]  txSwIdx,
  input  logic [IDX_W-1:0]  rxSwIdx,
  output ringStrobe_t       strobe,
  output logic [ADDR_W-1:0] txBase,
  output logic [ADDR_W-1:0] rxBase,
  output logic [IDX_W-1:0]  txLast,
  output logic [IDX_W-1:0]  rxLast,
  output logic              txIrq,
  output logic              rxIrq
);
  localparam logic [IDX_W-1:0] LAST_MAX = IDX_W'(MAX_DESC - 1);

  logic txMaskQ, rxMaskQ;
  logic unusedWrBits;

  function automatic logic [IDX_W-1:0] clampLast(input logic [DATA_W-1:0] v);
    if (v >= DATA_W'(MAX_DESC - 1)) return LAST_MAX;
    return v[IDX_W-1:0];
  endfunction

  function automatic logic wrHit(input logic [3:0] a);
    return regWrEn && (regAddr == a);
  endfunction

  assign unusedWrBits = ^regWrData;

  // Strobes qualified by ring state; refused requests never reach the datapath
  always_comb begin
    strobe.txHand    = wrHit(A_TX_DONE) && regWrData[0] && !flags.txFull;
    strobe.txRetire  = txEngDone && flags.txPending;
    strobe.rxFill    = rxEngDone && !flags.rxFull;
    strobe.rxRelease = wrHit(A_RX_DONE) && regWrData[0] && flags.rxReady;
    strobe.txRestart = wrHit(A_TX_LAST);
    strobe.rxRestart = wrHit(A_RX_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txBase  <= '0;
      rxBase  <= '0;
      txLast  <= LAST_MAX;
      rxLast  <= LAST_MAX;
      txMaskQ <= 1'b0;
      rxMaskQ <= 1'b0;
    end else begin
      if (wrHit(A_TX_BASE)) txBase  <= regWrData[ADDR_W-1:0];
      if (wrHit(A_RX_BASE)) rxBase  <= regWrData[ADDR_W-1:0];
      if (wrHit(A_TX_LAST)) txLast  <= clampLast(regWrData);
      if (wrHit(A_RX_LAST)) rxLast  <= clampLast(regWrData);
      if (wrHit(A_TX_MASK)) txMaskQ <= regWrData[0];
      if (wrHit(A_RX_MASK)) rxMaskQ <= regWrData[0];
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_TX_BASE: regRdData = DATA_W'(txBase);
      A_TX_LAST: regRdData = DATA_W'(txLast);
      A_TX_MASK: regRdData = DATA_W'(txMaskQ);
      A_TX_DONE: regRdData = DATA_W'(txSwIdx);
      A_TX_STAT: regRdData = DATA_W'(flags.txFull);
      A_RX_BASE: regRdData = DATA_W'(rxBase);
      A_RX_LAST: regRdData = DATA_W'(rxLast);
      A_RX_MASK: regRdData = DATA_W'(rxMaskQ);
      A_RX_DONE: regRdData = DATA_W'(rxSwIdx);
      A_RX_STAT: regRdData = DATA_W'({flags.rxErrHead, !flags.rxReady});
      default:   regRdData = '0;
    endcase
  end

  assign txIrq = txMaskQ && !flags.txFull;
  assign rxIrq = rxMaskQ && flags.rxReady;
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import ring_pkg::*;
#(
  parameter int MAX_DESC   = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_WORDS = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txEngDone,
  input  logic              rxEngDone,
  input  logic              rxEngErr,
  output logic              txFetchValid,
  output logic [ADDR_W-1:0] txFetchAddr,
  output logic              rxFetchValid,
  output logic [ADDR_W-1:0] rxFetchAddr,
  output logic              txIrq,
  output logic              rxIrq
);
  localparam int IDX_W      = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;

  ringStrobe_t       strobe;
  ringFlags_t        flags;
  logic [ADDR_W-1:0] txBase, rxBase;
  logic [IDX_W-1:0]  txLast, rxLast;
  logic [IDX_W-1:0]  txSwIdx, rxSwIdx, rxHwIdx;

  ring_ctrl #(
    .MAX_DESC(MAX_DESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txEngDone(txEngDone), .rxEngDone(rxEngDone),
    .flags(flags), .txSwIdx(txSwIdx), .rxSwIdx(rxSwIdx),
    .strobe(strobe), .txBase(txBase), .rxBase(rxBase),
    .txLast(txLast), .rxLast(rxLast), .txIrq(txIrq), .rxIrq(rxIrq));

  ring_datapath #(
    .MAX_DESC(MAX_DESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .rxEngErr(rxEngErr),
    .txBase(txBase), .rxBase(rxBase), .txLast(txLast), .rxLast(rxLast),
    .flags(flags), .txSwIdx(txSwIdx), .rxSwIdx(rxSwIdx), .rxHwIdx(rxHwIdx),
    .txFetchValid(txFetchValid), .txFetchAddr(txFetchAddr),
    .rxFetchValid(rxFetchValid), .rxFetchAddr(rxFetchAddr));
endmodule

// File: rtl/ring_tracker_checker.sv
module ring_tracker_checker
  import ring_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [3:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              txEngDone,
  input logic              rxEngDone,
  input logic              txIrq,
  input logic              rxIrq,
  input logic [ADDR_W-1:0] txFetchAddr,
  input ringFlags_t        flags,
  input logic [IDX_W-1:0]  txSwIdx,
  input logic [IDX_W-1:0]  rxSwIdx,
  input logic [IDX_W-1:0]  rxHwIdx
);
  assert_tx_irq_free_R8: assert property (@(posedge clk) disable iff (rst)
    txIrq |-> !flags.txFull);

  assert_rx_irq_ready_R8: assert property (@(posedge clk) disable iff (rst)
    rxIrq |-> flags.rxReady);

  assert_tx_hand_refused_R3: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == A_TX_DONE && regWrData[0] && flags.txFull)
    |=> $stable(txSwIdx));

  assert_rx_release_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == A_RX_DONE && regWrData[0] && !flags.rxReady)
    |=> $stable(rxSwIdx));

  assert_rx_fill_refused_R5: assert property (@(posedge clk) disable iff (rst)
    (rxEngDone && flags.rxFull && !(regWrEn && regAddr == A_RX_LAST))
    |=> $stable(rxHwIdx));

  assert_tx_fetch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!txEngDone && !(regWrEn && (regAddr == A_TX_BASE || regAddr == A_TX_LAST)))
    |=> $stable(txFetchAddr));
endmodule

bind desc_ring_tracker ring_tracker_checker #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .txEngDone(txEngDone), .rxEngDone(rxEngDone),
  .txIrq(txIrq), .rxIrq(rxIrq), .txFetchAddr(txFetchAddr), .flags(flags),
  .txSwIdx(txSwIdx), .rxSwIdx(rxSwIdx), .rxHwIdx(rxHwIdx));

// File: tb/desc_ring_tracker_tb_top.sv
module desc_ring_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_DESC   = 8;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;

  localparam logic [3:0] K_WR  = 4'd0; // register write
  localparam logic [3:0] K_RD  = 4'd1; // register read and compare
  localparam logic [3:0] K_TXE = 4'd2; // transmit completion pulse
  localparam logic [3:0] K_RXE = 4'd3; // receive completion pulse, data[0] = error
  localparam logic [3:0] K_TXF = 4'd4; // compare txFetchAddr
  localparam logic [3:0] K_RXF = 4'd5; // compare rxFetchAddr
  localparam logic [3:0] K_IRQ = 4'd6; // compare {rxIrq, txIrq}
  localparam logic [3:0] K_VLD = 4'd7; // compare {rxFetchValid, txFetchValid}

  typedef struct packed {
    logic [3:0]  kind;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 62;
  localparam vec_t VECS [NVEC] = '{
    '{K_WR,  4'h0, 32'h1000, 32'h0, 8'd10}, // R10 tx base
    '{K_WR,  4'h1, 32'd3,    32'h0, 8'd9},  // R9 four tx slots
    '{K_WR,  4'h2, 32'd1,    32'h0, 8'd8},
    '{K_RD,  4'h3, 32'h0,    32'd0, 8'd2},  // R2
    '{K_RD,  4'h4, 32'h0,    32'd0, 8'd3},  // R3
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_RD,  4'h3, 32'h0,    32'd3, 8'd2},
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_RD,  4'h3, 32'h0,    32'd0, 8'd2},  // R2 wrap
    '{K_RD,  4'h4, 32'h0,    32'd1, 8'd3},  // R3 full
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd3},  // refused
    '{K_RD,  4'h3, 32'h0,    32'd0, 8'd3},
    '{K_TXF, 4'h0, 32'h0,    32'h1000, 8'd4}, // R4
    '{K_TXE, 4'h0, 32'h0,    32'h0, 8'd4},
    '{K_RD,  4'h4, 32'h0,    32'd0, 8'd4},
    '{K_TXF, 4'h0, 32'h0,    32'h100C, 8'd4},
    '{K_TXE, 4'h0, 32'h0,    32'h0, 8'd4},
    '{K_TXE, 4'h0, 32'h0,    32'h0, 8'd4},
    '{K_TXE, 4'h0, 32'h0,    32'h0, 8'd4},
    '{K_VLD, 4'h0, 32'h0,    32'd2, 8'd4},
    '{K_TXE, 4'h0, 32'h0,    32'h0, 8'd4},  // ignored, ring empty
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd4},
    '{K_TXF, 4'h0, 32'h0,    32'h1000, 8'd4},
    '{K_WR,  4'h8, 32'h2000, 32'h0, 8'd10},
    '{K_WR,  4'h9, 32'd1,    32'h0, 8'd9},  // two rx slots
    '{K_WR,  4'hA, 32'd1,    32'h0, 8'd8},
    '{K_RD,  4'hC, 32'h0,    32'd1, 8'd6},  // R6
    '{K_IRQ, 4'h0, 32'h0,    32'd1, 8'd8},  // R8
    '{K_RXF, 4'h0, 32'h0,    32'h2000, 8'd5}, // R5
    '{K_RXE, 4'h0, 32'd0,    32'h0, 8'd5},
    '{K_RD,  4'hC, 32'h0,    32'd0, 8'd6},
    '{K_IRQ, 4'h0, 32'h0,    32'd3, 8'd8},
    '{K_RD,  4'hB, 32'h0,    32'd0, 8'd7},  // R7
    '{K_RXE, 4'h0, 32'd1,    32'h0, 8'd5},  // bad frame
    '{K_VLD, 4'h0, 32'h0,    32'd1, 8'd5},
    '{K_RXE, 4'h0, 32'd0,    32'h0, 8'd5},  // ignored, ring full
    '{K_RD,  4'hC, 32'h0,    32'd0, 8'd6},
    '{K_WR,  4'hB, 32'd1,    32'h0, 8'd7},
    '{K_RD,  4'hB, 32'h0,    32'd1, 8'd7},
    '{K_RD,  4'hC, 32'h0,    32'd2, 8'd6},  // error bit
    '{K_WR,  4'hB, 32'd1,    32'h0, 8'd7},  // bad frame released
    '{K_RD,  4'hB, 32'h0,    32'd0, 8'd7},
    '{K_RD,  4'hC, 32'h0,    32'd1, 8'd7},
    '{K_WR,  4'hB, 32'd1,    32'h0, 8'd7},  // ignored, nothing pending
    '{K_RD,  4'hB, 32'h0,    32'd0, 8'd7},
    '{K_IRQ, 4'h0, 32'h0,    32'd1, 8'd8},
    '{K_WR,  4'h2, 32'd0,    32'h0, 8'd8},
    '{K_IRQ, 4'h0, 32'h0,    32'd0, 8'd8},
    '{K_RD,  4'h2, 32'h0,    32'd0, 8'd10},
    '{K_RD,  4'h0, 32'h0,    32'h1000, 8'd10},
    '{K_RD,  4'h9, 32'h0,    32'd1, 8'd10},
    '{K_WR,  4'h1, 32'd2,    32'h0, 8'd9},  // R9 restart, three slots
    '{K_RD,  4'h3, 32'h0,    32'd0, 8'd9},
    '{K_VLD, 4'h0, 32'h0,    32'd2, 8'd9},
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_RD,  4'h3, 32'h0,    32'd2, 8'd2},
    '{K_WR,  4'h3, 32'd1,    32'h0, 8'd2},
    '{K_RD,  4'h3, 32'h0,    32'd0, 8'd2},
    '{K_RD,  4'h4, 32'h0,    32'd1, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic txEngDone = 1'b0, rxEngDone = 1'b0, rxEngErr = 1'b0;
  logic txFetchValid, rxFetchValid, txIrq, rxIrq;
  logic [ADDR_W-1:0] txFetchAddr, rxFetchAddr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_tracker #(.MAX_DESC(MAX_DESC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txEngDone(txEngDone), .rxEngDone(rxEngDone), .rxEngErr(rxEngErr),
    .txFetchValid(txFetchValid), .txFetchAddr(txFetchAddr),
    .rxFetchValid(rxFetchValid), .rxFetchAddr(rxFetchAddr),
    .txIrq(txIrq), .rxIrq(rxIrq));

  task automatic check(input logic [31:0] act, input logic [31:0] expv,
                       input int req, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [3:0] a, input logic [31:0] e,
                          input int req, input string what);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData, e, req, what);
  endtask

  task automatic pulse(input bit tx, input bit err);
    @(negedge clk);
    if (tx) txEngDone = 1'b1; else begin rxEngDone = 1'b1; rxEngErr = err; end
    @(negedge clk);
    txEngDone = 1'b0; rxEngDone = 1'b0; rxEngErr = 1'b0;
  endtask

  task automatic portCheck(input logic [3:0] kind, input logic [31:0] e, input int req);
    @(negedge clk);
    #1;
    case (kind)
      K_TXF:   check(txFetchAddr, e, req, "txFetchAddr");
      K_RXF:   check(rxFetchAddr, e, req, "rxFetchAddr");
      K_IRQ:   check({30'b0, rxIrq, txIrq}, e, req, "irq {rx,tx}");
      default: check({30'b0, rxFetchValid, txFetchValid}, e, req, "fetch valid {rx,tx}");
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    regCheck(4'h3, 32'd0, 1, "tx index after reset");
    regCheck(4'hB, 32'd0, 1, "rx index after reset");
    regCheck(4'h4, 32'd0, 1, "tx status after reset");
    regCheck(4'hC, 32'd1, 1, "rx status after reset");
    regCheck(4'h1, 32'd7, 1, "tx last after reset");
    portCheck(K_IRQ, 32'd0, 1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].kind)
        K_WR:  regWrite(VECS[i].addr, VECS[i].data);
        K_RD:  regCheck(VECS[i].addr, VECS[i].expv, int'(VECS[i].req), "register read");
        K_TXE: pulse(1'b1, 1'b0);
        K_RXE: pulse(1'b0, VECS[i].data[0]);
        default: portCheck(VECS[i].kind, VECS[i].expv, int'(VECS[i].req));
      endcase
    end

    // R3/R4: done strobe on a full ring meets a retire in the same cycle
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h3; regWrData = 32'd1; txEngDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; txEngDone = 1'b0;
    regCheck(4'h3, 32'd0, 3, "tx index, strobe refused while full");
    regCheck(4'h4, 32'd0, 4, "tx status after retire");

    // R2/R4: both accepted in the same cycle
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h3; regWrData = 32'd1; txEngDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; txEngDone = 1'b0;
    regCheck(4'h3, 32'd1, 2, "tx index, concurrent hand");
    portCheck(K_TXF, 32'h1018, 4);

    // R9 clamp of an oversized last index
    regWrite(4'h9, 32'd20);
    regCheck(4'h9, 32'd7, 9, "rx last clamped");

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    regCheck(4'h3, 32'd0, 1, "tx index after second reset");
    regCheck(4'h0, 32'd0, 1, "tx base after second reset");
    portCheck(K_IRQ, 32'd0, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule